// File: doc/BRIEF.md
# Chip-Select-Framed SAR Converter Serial Controller

This block is the digital side of a successive-approximation converter. One active-low select line both starts a conversion and frames the serial read-out. The block runs on a fast system clock and sees the select line and the serial clock only through synchronisers. It detects their edges inside its own clock domain. A 16-bit result arrives on a parallel port and is captured at the moment select falls. The block then shifts out a 24-bit frame: four leading zeros, the result MSB first, and four trailing zeros. The frame advances on serial-clock falling edges. The block also drives the hold control for the track-and-hold and an enable that stands in for a three-state output pin.

Power management has no register. It follows from how many serial-clock falling edges have passed when select rises again. A short frame puts the block to sleep. A frame cut off before the second edge is treated as a glitch and ignored. A frame stopped after the tenth edge aborts the conversion but keeps the block powered. When the block is asleep, the next select fall begins a wake-up conversion. That frame carries an all-zero word, and the block is fully powered once the tenth edge arrives.

The result port has no valid/ready handshake and no back-pressure. Its value is sampled once, in the cycle the synchronised select fall is seen, and is ignored at all other times. Each phase of the serial clock, and each level of the select line, must last at least four system clocks. Every output responds on the third system clock edge after the pin that caused it changes.

Top module: `sar_frame_ctrl`

## Requirements
- R1: A select fall sets hold high and the output enable high. It also drives a 0 on the data output and captures the result word.
- R2: Let k count the serial-clock falling edges since the select fall. After edge k, the data output shows 0 for k = 1 to 3. It shows result bit (19 - k) for k = 4 to 19. It shows 0 for k = 20 to 23.
- R3: The 24th falling edge clears the output enable. Later serial-clock edges do not set it again until the next select fall.
- R4: A select rise clears the output enable and hold at once, whatever the edge count.
- R5: Hold stays high up to and including the serial-clock rise that follows the 16th falling edge. It goes low on the first serial-clock rise after the 17th falling edge.
- R6: When powered, a select rise after 2 to 9 falling edges sets the powered-down flag.
- R7: When powered, a select rise after 0 or 1 falling edges leaves the powered-down flag low.
- R8: When powered, a select rise after 10 or more falling edges leaves the powered-down flag low.
- R9: When powered down, a select fall starts a wake-up frame. The powered-down flag clears on that frame's 10th falling edge. A select rise before that edge leaves the flag set.
- R10: A frame that begins while the block is powered down shifts an all-zero word in place of the result input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_in | input | 1 | Asynchronous active-low select / conversion start |
| sclk_in | input | 1 | Asynchronous serial clock |
| result_in | input | 16 | Parallel conversion result, captured at the select fall |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Data output enable (low stands for high impedance) |
| hold | output | 1 | Track-and-hold control, high means hold |
| powered_down | output | 1 | High while asleep or during a wake-up frame |

## Verification
On every cycle, the assertions check the following local rules. The outputs respond correctly to a select fall and a select rise. The data output stays zero outside the data window. The enable drops on the last frame edge. Hold is released only by a select rise or a serial-clock rise. The power state obeys the glitch and wake rules. Several behaviours show up only in the bench's frame scenarios. These are the exact bit order of each result, the edge-count boundaries at 2, 10, 17 and 24, the zeroed word during wake-up, and the absence of any effect from idle serial clocks. The bench sweeps every possible frame length from 0 to 24 edges, starting from the powered state, and follows each power-down with a short wake-up and then a full wake-up.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PWR_ON   = 2'd0,
    PWR_OFF  = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= RST_VAL;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq #(
  parameter int DATA_W     = 16,
  parameter int LEAD_Z     = 4,
  parameter int TRAIL_Z    = 4,
  parameter int TRACK_EDGE = 17,
  localparam int FRAME_LEN = LEAD_Z + DATA_W + TRAIL_Z,
  localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_fall,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] result_in,
  input  logic              zero_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold,
  output logic              active,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] DATA_LO = CNT_W'(LEAD_Z);
  localparam logic [CNT_W-1:0] DATA_HI = CNT_W'(LEAD_Z + DATA_W);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] TRACK   = CNT_W'(TRACK_EDGE);

  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt_nx;
  logic              in_data;

  assign cnt_nx  = cnt + 1'b1;
  assign in_data = (cnt_nx >= DATA_LO) && (cnt_nx < DATA_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sreg   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      hold   <= 1'b0;
    end else if (cs_fall) begin
      active <= 1'b1;
      cnt    <= '0;
      sreg   <= zero_word ? '0 : result_in;
      sdo    <= 1'b0;
      sdo_oe <= 1'b1;
      hold   <= 1'b1;
    end else if (cs_rise) begin
      active <= 1'b0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      hold   <= 1'b0;
    end else if (active && sclk_fall) begin
      cnt <= cnt_nx;
      if (cnt_nx == LAST) begin
        active <= 1'b0;
        sdo_oe <= 1'b0;
        sdo    <= 1'b0;
      end else if (in_data) begin
        sdo  <= sreg[DATA_W-1];
        sreg <= {sreg[DATA_W-2:0], 1'b0};
      end else begin
        sdo <= 1'b0;
      end
    end else if (active && sclk_rise && cnt >= TRACK) begin
      hold <= 1'b0;
    end
  end

  a_r1_fall_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe && hold && !sdo));

  a_r2_zero_outside_data: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && (cnt < DATA_LO || cnt >= DATA_HI)) |-> !sdo);

  a_r3_last_edge_tristates: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sclk_fall && !cs_fall && !cs_rise && cnt == LAST - 1'b1) |=> !sdo_oe);

  a_r4_rise_tristates: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !cs_fall) |=> (!sdo_oe && !hold));

  a_r5_hold_release_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(cs_rise || sclk_rise));
endmodule

// File: rtl/sar_power_ctl.sv
module sar_power_ctl
  import sar_pkg::*;
#(
  parameter int PD_MIN_EDGE = 2,
  parameter int WAKE_EDGE   = 10,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_fall,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  output logic             zero_word,
  output logic             powered_down
);
  localparam logic [CNT_W-1:0] PD_MIN = CNT_W'(PD_MIN_EDGE);
  localparam logic [CNT_W-1:0] WAKE   = CNT_W'(WAKE_EDGE);

  pwr_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      PWR_ON:   if (cs_rise && !cs_fall && cnt >= PD_MIN && cnt < WAKE) state_nx = PWR_OFF;
      PWR_OFF:  if (cs_fall) state_nx = PWR_WAKE;
      PWR_WAKE: begin
        if (cs_rise && !cs_fall) state_nx = PWR_OFF;
        else if (!cs_fall && active && sclk_fall && cnt == WAKE - 1'b1) state_nx = PWR_ON;
      end
      default:  state_nx = PWR_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PWR_ON;
    else        state <= state_nx;
  end

  assign zero_word    = (state == PWR_OFF);
  assign powered_down = (state != PWR_ON);

  a_r7_glitch_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_ON && cs_rise && cnt < PD_MIN) |=> !powered_down);

  a_r9_fall_starts_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_OFF && cs_fall) |=> (state == PWR_WAKE && powered_down));

  a_r8_late_rise_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_ON && cs_rise && cnt >= WAKE) |=> !powered_down);
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl #(
  parameter int DATA_W      = 16,
  parameter int LEAD_Z      = 4,
  parameter int TRAIL_Z     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PD_MIN_EDGE = 2,
  parameter int WAKE_EDGE   = 10,
  parameter int TRACK_EDGE  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_in,
  input  logic              sclk_in,
  input  logic [DATA_W-1:0] result_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold,
  output logic              powered_down
);
  localparam int FRAME_LEN = LEAD_Z + DATA_W + TRAIL_Z;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic             cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic             active, zero_word;
  logic [CNT_W-1:0] cnt;

  sar_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n_in), .rise(cs_rise), .fall(cs_fall)
  );

  sar_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk_in), .rise(sclk_rise), .fall(sclk_fall)
  );

  sar_frame_seq #(
    .DATA_W(DATA_W), .LEAD_Z(LEAD_Z), .TRAIL_Z(TRAIL_Z), .TRACK_EDGE(TRACK_EDGE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .result_in(result_in),
    .zero_word(zero_word), .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold),
    .active(active), .cnt(cnt)
  );

  sar_power_ctl #(
    .PD_MIN_EDGE(PD_MIN_EDGE), .WAKE_EDGE(WAKE_EDGE), .CNT_W(CNT_W)
  ) u_pwr (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .active(active), .cnt(cnt),
    .zero_word(zero_word), .powered_down(powered_down)
  );
endmodule

// File: tb/sar_frame_ctrl_bench.sv
`timescale 1ns/1ps
module sar_frame_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n_in = 1'b1;
  logic        sclk_in = 1'b1;
  logic [15:0] result_in = '0;
  logic        sdo, sdo_oe, hold, powered_down;

  int checks = 0;
  int fails  = 0;
  int pstate = 0;  // 0 powered, 1 asleep, 2 waking
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sar_frame_ctrl u_sar_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
    .result_in(result_in), .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold),
    .powered_down(powered_down)
  );

  task automatic step();
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic [15:0] w);
    if (k >= 4 && k <= 19) return w[19-k];
    return 1'b0;
  endfunction

  task automatic do_frame(input logic [15:0] w, input int n);
    logic [15:0] eff;
    bit was_off;
    bit was_on;
    string rq;
    was_off = (pstate == 1);
    was_on  = (pstate == 0);
    eff = was_off ? 16'h0000 : w;
    if (was_off) pstate = 2;
    result_in = w;
    cs_n_in = 1'b0; step();
    result_in = ~w;
    chk("R1", sdo_oe, 1); chk("R1", sdo, 0); chk("R1", hold, 1);
    chk(was_off ? "R9" : "R1", powered_down, pstate != 0);
    for (int k = 1; k <= n; k++) begin
      sclk_in = 1'b0; step();
      if (pstate == 2 && k == 10) pstate = 0;
      if (k < 24) begin
        rq = was_off ? "R10" : "R2";
        chk(rq, sdo_oe, 1);
        chk(rq, sdo, exp_bit(k, eff));
      end else begin
        chk("R3", sdo_oe, 0);
      end
      chk(was_off ? "R9" : "R8", powered_down, pstate != 0);
      sclk_in = 1'b1; step();
      chk("R5", hold, (k < 17) ? 1 : 0);
    end
    cs_n_in = 1'b1; step();
    chk("R4", sdo_oe, 0); chk("R4", hold, 0);
    if (pstate == 2) begin
      pstate = 1; rq = "R9";
    end else if (was_on && n >= 2 && n < 10) begin
      pstate = 1; rq = "R6";
    end else if (was_on && n < 2) begin
      rq = "R7";
    end else begin
      rq = was_on ? "R8" : "R9";
    end
    chk(rq, powered_down, pstate != 0);
    // idle serial clocks with select high must not restart the output
    sclk_in = 1'b0; step(); chk("R3", sdo_oe, 0);
    sclk_in = 1'b1; step(); chk("R3", sdo_oe, 0); chk("R3", sdo, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", sdo_oe, 0); chk("R1", hold, 0); chk("R6", powered_down, 0); chk("R2", sdo, 0);
    rst_n = 1'b1; step();
    do_frame(16'hFFFF, 24);
    do_frame(16'h0001, 24);
    do_frame(16'h8000, 24);
    for (int n = 0; n <= 24; n++) begin
      do_frame(16'hA5C3 ^ 16'(n * 16'h1357), n);
      if (pstate == 1) begin
        do_frame(16'h5A3C, n % 10);
        do_frame(16'hC0DE, 24);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule